// File: doc/BRIEF.md
# Indirect SDRAM Bank Configuration Unit

This unit is the software-facing configuration and status front end of a memory controller with a parameterized number of banks (four by default). Software never addresses the internal registers directly. It first writes an internal offset into a pointer port, and then reads or writes the selected register through a window port. Each internal register has its own write mask. Some registers also have side effects: write-one-to-clear status, a status word that follows the edges of configuration bits, and an ECC error status word that drives an interrupt line.

The bank control words hold a base address, a power-of-two size code and an enable bit. A combinational decoder uses these words to map an incoming 32-bit address to a bank hit and a bank index. The decoder is active only while the controller-enable bit of the configuration word is set. This unit does not sequence SDRAM commands, generate refresh or compute ECC.

Top module: `sdram_cfg_unit`

## Requirements
- R1: After reset the data window reads the following values. The refresh word (offset 0x30) reads 0x05F00000. The power word (offset 0x34) reads 0x07C00000. The configuration word (offset 0x20) reads 0x00800000. Every other stored word reads 0. The interrupt output is low and no address hits.
- R2: A write to register index 0x10 loads the pointer, and a read of index 0x10 returns the pointer. Reads and writes at index 0x11 access the internal word selected by the pointer. The error address word (offset 0x10) stores all 32 bits.
- R3: Through the data window, the timing offset 0x80 and any offset that is not defined read as 0xFFFFFFFF. A register index other than 0x10 or 0x11 reads 0, and a write to such an index changes nothing.
- R4: The error status words at offsets 0x00 and 0x08 are write-one-to-clear. A written 1 clears the bit, and a written 0 leaves it unchanged.
- R5: The status word (offset 0x24) ignores data-window writes. It changes only through the configuration side effects described in R6 and R7.
- R6: A configuration write stores the value masked with 0xFFE00000. When configuration bit 31 goes from 0 to 1, status bit 31 is cleared. When it goes from 1 to 0, status bit 31 is set, and the decoder stops reporting hits for every bank.
- R7: When configuration bit 30 goes from 0 to 1, status bit 30 is set. When it goes from 1 to 0, status bit 30 is cleared.
- R8: The refresh word stores the value masked with 0x3FF80000. The ECC configuration word (offset 0x94) stores the value masked with 0x00F00000. The power word stores (value AND 0xF8000000) OR 0x07C00000. The timing word stores the value masked with 0x018FC01F and still reads as all ones.
- R9: Bank n's control word sits at offset 0x40+4n and stores the value masked with 0xFFDEE001. In that word, bit 0 is the enable, bits 31:23 are the base address and bits 19:17 are the size code. The bank size is 4 MiB shifted left by the size code.
- R10: The ECC error status word (offset 0x98) stores the value masked with 0xFFF0F000. The interrupt rises when the word goes from zero to nonzero and falls when it goes from nonzero to zero.
- R11: The decoder reports a hit for bank n only if all of these hold: configuration bit 31 is set, bank n's enable bit is set, and the address lies in [base, base+size). The range arithmetic does not wrap at 2^32.
- R12: A bank with size code 7 never hits.
- R13: When several banks match an address, the decoder reports the lowest-numbered bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_idx_i | input | 10 | Register index: pointer port 0x10, data window 0x11 |
| reg_we_i | input | 1 | Write strobe, takes effect at the rising clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_idx_i |
| ecc_irq_o | output | 1 | ECC error interrupt |
| dec_addr_i | input | 32 | Address to decode |
| dec_hit_o | output | 1 | Address falls in an enabled, valid bank |
| dec_bank_o | output | 2 | Index of the hitting bank |

## Verification
Random writes of arbitrary 32-bit values to every defined offset, mixed with undefined offsets, separate a correct per-register mask from a shared or shifted one. Back-to-back configuration writes with random bit 31 and bit 30 values separate true edge detection from level copying of the status bits. Decode addresses are chosen at each bank's base, at base+size-1, at base+size and at random offsets. These show off-by-one limits, the size-code shift and the code-7 exclusion. Directed overlapping banks and a bank that ends exactly at 2^32 show the priority order and the carry handling in the range compare.

// File: rtl/sdram_cfg_pkg.sv
`timescale 1ns/1ps
package sdram_cfg_pkg;
  localparam int DW = 32;
  typedef logic [DW-1:0] word_t;

  // internal offsets behind the data window
  localparam word_t OFF_ERR0  = 32'h00;
  localparam word_t OFF_ERR1  = 32'h08;
  localparam word_t OFF_EADDR = 32'h10;
  localparam word_t OFF_CFG   = 32'h20;
  localparam word_t OFF_STAT  = 32'h24;
  localparam word_t OFF_RFSH  = 32'h30;
  localparam word_t OFF_PWR   = 32'h34;
  localparam word_t OFF_BANK0 = 32'h40;
  localparam word_t OFF_TIM   = 32'h80;
  localparam word_t OFF_ECFG  = 32'h94;
  localparam word_t OFF_ESR   = 32'h98;

  localparam word_t MSK_CFG  = 32'hFFE0_0000;
  localparam word_t MSK_BANK = 32'hFFDE_E001;
  localparam word_t MSK_RFSH = 32'h3FF8_0000;
  localparam word_t MSK_TIM  = 32'h018F_C01F;
  localparam word_t MSK_ECFG = 32'h00F0_0000;
  localparam word_t MSK_ESR  = 32'hFFF0_F000;
  localparam word_t MSK_PWR  = 32'hF800_0000;
  localparam word_t FIX_PWR  = 32'h07C0_0000;

  localparam word_t RST_PWR  = 32'h07C0_0000;
  localparam word_t RST_RFSH = 32'h05F0_0000;
  localparam word_t RST_TIM  = 32'h0085_4009;
  localparam word_t RST_CFG  = 32'h0080_0000;

  localparam int CFG_EN_BIT   = 31;
  localparam int CFG_AUX_BIT  = 30;
  localparam int BANK_EN_BIT  = 0;
  localparam int BANK_CODE_LO = 17;
  localparam int BANK_BASE_LO = 23;
  localparam int UNIT_LOG2    = 22;
  localparam logic [2:0] CODE_BAD = 3'd7;

  function automatic word_t bank_off(int unsigned n);
    return OFF_BANK0 + word_t'(4 * n);
  endfunction
endpackage

// File: rtl/sdram_cfg_regs.sv
`timescale 1ns/1ps
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ptr_we_i,
  input  logic                    win_we_i,
  input  word_t                   wdata_i,
  output word_t                   ptr_o,
  output word_t                   err0_o,
  output word_t                   err1_o,
  output word_t                   eaddr_o,
  output word_t                   cfg_o,
  output word_t                   stat_o,
  output word_t                   rfsh_o,
  output word_t                   pwr_o,
  output word_t                   tim_o,
  output word_t                   ecfg_o,
  output word_t                   esr_o,
  output logic [NUM_BANKS*DW-1:0] bank_o,
  output logic                    irq_o
);
  word_t ptr_q, err0_q, err1_q, eaddr_q, cfg_q, stat_q;
  word_t rfsh_q, pwr_q, tim_q, ecfg_q, esr_q;
  logic  irq_q;
  word_t cfg_new, stat_nxt, esr_new;

  always_comb begin
    cfg_new  = wdata_i & MSK_CFG;
    esr_new  = wdata_i & MSK_ESR;
    stat_nxt = stat_q;
    if (!cfg_q[CFG_EN_BIT] && cfg_new[CFG_EN_BIT])      stat_nxt[CFG_EN_BIT] = 1'b0;
    else if (cfg_q[CFG_EN_BIT] && !cfg_new[CFG_EN_BIT]) stat_nxt[CFG_EN_BIT] = 1'b1;
    if (!cfg_q[CFG_AUX_BIT] && cfg_new[CFG_AUX_BIT])      stat_nxt[CFG_AUX_BIT] = 1'b1;
    else if (cfg_q[CFG_AUX_BIT] && !cfg_new[CFG_AUX_BIT]) stat_nxt[CFG_AUX_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      err0_q  <= '0;
      err1_q  <= '0;
      eaddr_q <= '0;
      cfg_q   <= RST_CFG;
      stat_q  <= '0;
      rfsh_q  <= RST_RFSH;
      pwr_q   <= RST_PWR;
      tim_q   <= RST_TIM;
      ecfg_q  <= '0;
      esr_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ptr_we_i) ptr_q <= wdata_i;
      if (win_we_i) begin
        case (ptr_q)
          OFF_ERR0:  err0_q  <= err0_q & ~wdata_i;
          OFF_ERR1:  err1_q  <= err1_q & ~wdata_i;
          OFF_EADDR: eaddr_q <= wdata_i;
          OFF_CFG: begin
            cfg_q  <= cfg_new;
            stat_q <= stat_nxt;
          end
          OFF_RFSH:  rfsh_q  <= wdata_i & MSK_RFSH;
          OFF_PWR:   pwr_q   <= (wdata_i & MSK_PWR) | FIX_PWR;
          OFF_TIM:   tim_q   <= wdata_i & MSK_TIM;
          OFF_ECFG:  ecfg_q  <= wdata_i & MSK_ECFG;
          OFF_ESR: begin
            esr_q <= esr_new;
            if (esr_q == '0 && esr_new != '0)      irq_q <= 1'b1;
            else if (esr_q != '0 && esr_new == '0) irq_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
    localparam word_t MY_OFF = bank_off(n);
    word_t bank_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          bank_q <= '0;
      else if (win_we_i && ptr_q == MY_OFF) bank_q <= wdata_i & MSK_BANK;
    end
    assign bank_o[n*DW +: DW] = bank_q;
  end

  assign ptr_o   = ptr_q;
  assign err0_o  = err0_q;
  assign err1_o  = err1_q;
  assign eaddr_o = eaddr_q;
  assign cfg_o   = cfg_q;
  assign stat_o  = stat_q;
  assign rfsh_o  = rfsh_q;
  assign pwr_o   = pwr_q;
  assign tim_o   = tim_q;
  assign ecfg_o  = ecfg_q;
  assign esr_o   = esr_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/sdram_cfg_rdmux.sv
`timescale 1ns/1ps
module sdram_cfg_rdmux
  import sdram_cfg_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter int          IDX_W     = 10,
  parameter logic [9:0]  PTR_IDX   = 10'h010,
  parameter logic [9:0]  WIN_IDX   = 10'h011
) (
  input  logic [IDX_W-1:0]        idx_i,
  input  word_t                   ptr_i,
  input  word_t                   err0_i,
  input  word_t                   err1_i,
  input  word_t                   eaddr_i,
  input  word_t                   cfg_i,
  input  word_t                   stat_i,
  input  word_t                   rfsh_i,
  input  word_t                   pwr_i,
  input  word_t                   ecfg_i,
  input  word_t                   esr_i,
  input  logic [NUM_BANKS*DW-1:0] bank_i,
  output word_t                   rdata_o
);
  word_t win_d;

  always_comb begin
    win_d = '1;  // undefined offsets and the timing word read as all ones
    case (ptr_i)
      OFF_ERR0:  win_d = err0_i;
      OFF_ERR1:  win_d = err1_i;
      OFF_EADDR: win_d = eaddr_i;
      OFF_CFG:   win_d = cfg_i;
      OFF_STAT:  win_d = stat_i;
      OFF_RFSH:  win_d = rfsh_i;
      OFF_PWR:   win_d = pwr_i;
      OFF_ECFG:  win_d = ecfg_i;
      OFF_ESR:   win_d = esr_i;
      default: ;
    endcase
    for (int n = 0; n < NUM_BANKS; n++)
      if (ptr_i == bank_off(n)) win_d = bank_i[n*DW +: DW];
  end

  always_comb begin
    if (idx_i == IDX_W'(PTR_IDX))      rdata_o = ptr_i;
    else if (idx_i == IDX_W'(WIN_IDX)) rdata_o = win_d;
    else                               rdata_o = '0;
  end
endmodule

// File: rtl/sdram_bank_decoder.sv
`timescale 1ns/1ps
module sdram_bank_decoder
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                    ctrl_en_i,
  input  logic [NUM_BANKS*DW-1:0] bank_i,
  input  word_t                   addr_i,
  output logic                    hit_o,
  output logic [BW-1:0]           bank_o
);
  logic [NUM_BANKS-1:0] match;

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_match
    word_t       w;
    logic [2:0]  code;
    logic [DW:0] base, lim, size;
    assign w    = bank_i[n*DW +: DW];
    assign code = w[BANK_CODE_LO +: 3];
    assign base = {1'b0, w[DW-1:BANK_BASE_LO], {BANK_BASE_LO{1'b0}}};
    assign size = (DW+1)'(1) << (UNIT_LOG2 + int'(code));
    assign lim  = base + size;
    // 33-bit compare so a bank ending at 2^32 still covers the top address
    assign match[n] = ctrl_en_i && w[BANK_EN_BIT] && (code != CODE_BAD) &&
                      ({1'b0, addr_i} >= base) && ({1'b0, addr_i} < lim);
  end

  always_comb begin
    hit_o  = 1'b0;
    bank_o = '0;
    for (int n = NUM_BANKS - 1; n >= 0; n--) begin
      if (match[n]) begin
        hit_o  = 1'b1;
        bank_o = BW'(n);
      end
    end
  end
endmodule

// File: rtl/sdram_cfg_unit.sv
`timescale 1ns/1ps
module sdram_cfg_unit
  import sdram_cfg_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter int         IDX_W     = 10,
  parameter logic [9:0] PTR_IDX   = 10'h010,
  parameter logic [9:0] WIN_IDX   = 10'h011,
  localparam int        BW        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic             reg_we_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             ecc_irq_o,
  input  logic [31:0]      dec_addr_i,
  output logic             dec_hit_o,
  output logic [BW-1:0]    dec_bank_o
);
  word_t ptr_w, err0_w, err1_w, eaddr_w, cfg_w, stat_w;
  word_t rfsh_w, pwr_w, tim_w, ecfg_w, esr_w;
  logic [NUM_BANKS*DW-1:0] bank_w;
  logic ptr_we, win_we;

  assign ptr_we = reg_we_i && (reg_idx_i == IDX_W'(PTR_IDX));
  assign win_we = reg_we_i && (reg_idx_i == IDX_W'(WIN_IDX));

  sdram_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ptr_we_i(ptr_we),
    .win_we_i(win_we),
    .wdata_i (reg_wdata_i),
    .ptr_o   (ptr_w),
    .err0_o  (err0_w),
    .err1_o  (err1_w),
    .eaddr_o (eaddr_w),
    .cfg_o   (cfg_w),
    .stat_o  (stat_w),
    .rfsh_o  (rfsh_w),
    .pwr_o   (pwr_w),
    .tim_o   (tim_w),
    .ecfg_o  (ecfg_w),
    .esr_o   (esr_w),
    .bank_o  (bank_w),
    .irq_o   (ecc_irq_o)
  );

  sdram_cfg_rdmux #(
    .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .PTR_IDX(PTR_IDX), .WIN_IDX(WIN_IDX)
  ) u_rdmux (
    .idx_i  (reg_idx_i),
    .ptr_i  (ptr_w),
    .err0_i (err0_w),
    .err1_i (err1_w),
    .eaddr_i(eaddr_w),
    .cfg_i  (cfg_w),
    .stat_i (stat_w),
    .rfsh_i (rfsh_w),
    .pwr_i  (pwr_w),
    .ecfg_i (ecfg_w),
    .esr_i  (esr_w),
    .bank_i (bank_w),
    .rdata_o(reg_rdata_o)
  );

  sdram_bank_decoder #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .ctrl_en_i(cfg_w[CFG_EN_BIT]),
    .bank_i   (bank_w),
    .addr_i   (dec_addr_i),
    .hit_o    (dec_hit_o),
    .bank_o   (dec_bank_o)
  );
endmodule

// File: rtl/sdram_cfg_unit_chk.sv
`timescale 1ns/1ps
module sdram_cfg_unit_chk
  import sdram_cfg_pkg::*;
#(
  parameter int  NUM_BANKS = 4,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input word_t                   cfg_i,
  input word_t                   stat_i,
  input word_t                   esr_i,
  input word_t                   tim_i,
  input word_t                   pwr_i,
  input logic [NUM_BANKS*DW-1:0] bank_i,
  input logic                    irq_i,
  input logic                    hit_i,
  input logic [BW-1:0]           hit_bank_i
);
  word_t sel_bank;
  assign sel_bank = bank_i[32'(hit_bank_i) * DW +: DW];

  a_r6_enable_clears_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_i[CFG_EN_BIT]) |-> !stat_i[CFG_EN_BIT]);
  a_r6_disable_sets_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_i[CFG_EN_BIT]) |-> stat_i[CFG_EN_BIT]);
  a_r7_aux_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_i[CFG_AUX_BIT]) |-> stat_i[CFG_AUX_BIT]);
  a_r7_aux_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_i[CFG_AUX_BIT]) |-> !stat_i[CFG_AUX_BIT]);
  a_r5_stat_only_by_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_i[CFG_EN_BIT:CFG_AUX_BIT]) |-> $stable(stat_i));
  a_r10_irq_tracks_esr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (esr_i != '0));
  a_r10_esr_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esr_i & ~MSK_ESR) == '0);
  a_r8_tim_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tim_i & ~MSK_TIM) == '0);
  a_r8_pwr_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i & FIX_PWR) == FIX_PWR);
  a_r11_hit_needs_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> cfg_i[CFG_EN_BIT]);
  a_r12_hit_valid_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (sel_bank[BANK_EN_BIT] && sel_bank[BANK_CODE_LO +: 3] != CODE_BAD));

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank_chk
    a_r9_bank_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_i[n*DW +: DW] & ~MSK_BANK) == '0);
  end
endmodule

bind sdram_cfg_unit sdram_cfg_unit_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_i     (cfg_w),
  .stat_i    (stat_w),
  .esr_i     (esr_w),
  .tim_i     (tim_w),
  .pwr_i     (pwr_w),
  .bank_i    (bank_w),
  .irq_i     (ecc_irq_o),
  .hit_i     (dec_hit_o),
  .hit_bank_i(dec_bank_o)
);

// File: tb/sdram_cfg_unit_tb.sv
`timescale 1ns/1ps
module sdram_cfg_unit_tb;
  localparam logic [9:0] PI = 10'h010;
  localparam logic [9:0] WI = 10'h011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  idx = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] daddr = '0;
  logic        hit;
  logic [1:0]  hbank;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_ptr, m_err0, m_err1, m_eaddr, m_cfg, m_stat, m_rfsh, m_pwr, m_ecfg, m_esr;
  logic [31:0] m_bank [4];
  logic        m_irq;

  always #5 clk = ~clk;

  sdram_cfg_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(idx), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ecc_irq_o(irq),
    .dec_addr_i(daddr), .dec_hit_o(hit), .dec_bank_o(hbank)
  );

  task automatic model_reset();
    m_ptr = 0; m_err0 = 0; m_err1 = 0; m_eaddr = 0; m_cfg = 32'h0080_0000;
    m_stat = 0; m_rfsh = 32'h05F0_0000; m_pwr = 32'h07C0_0000; m_ecfg = 0;
    m_esr = 0; m_irq = 0;
    for (int n = 0; n < 4; n++) m_bank[n] = 0;
  endtask

  task automatic model_win_write(input logic [31:0] off, input logic [31:0] v);
    logic [31:0] c, e;
    case (off)
      32'h00: m_err0 &= ~v;
      32'h08: m_err1 &= ~v;
      32'h10: m_eaddr = v;
      32'h20: begin
        c = v & 32'hFFE0_0000;
        if (!m_cfg[31] && c[31]) m_stat[31] = 0;
        if (m_cfg[31] && !c[31]) m_stat[31] = 1;
        if (!m_cfg[30] && c[30]) m_stat[30] = 1;
        if (m_cfg[30] && !c[30]) m_stat[30] = 0;
        m_cfg = c;
      end
      32'h30: m_rfsh = v & 32'h3FF8_0000;
      32'h34: m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
      32'h40, 32'h44, 32'h48, 32'h4C: m_bank[(off - 32'h40) >> 2] = v & 32'hFFDE_E001;
      32'h94: m_ecfg = v & 32'h00F0_0000;
      32'h98: begin
        e = v & 32'hFFF0_F000;
        if (m_esr == 0 && e != 0) m_irq = 1;
        if (m_esr != 0 && e == 0) m_irq = 0;
        m_esr = e;
      end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [9:0] i);
    if (i == PI) return m_ptr;
    if (i != WI) return 0;
    case (m_ptr)
      32'h00: return m_err0;
      32'h08: return m_err1;
      32'h10: return m_eaddr;
      32'h20: return m_cfg;
      32'h24: return m_stat;
      32'h30: return m_rfsh;
      32'h34: return m_pwr;
      32'h40: return m_bank[0];
      32'h44: return m_bank[1];
      32'h48: return m_bank[2];
      32'h4C: return m_bank[3];
      32'h94: return m_ecfg;
      32'h98: return m_esr;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [2:0] model_dec(input logic [31:0] a);
    logic [63:0] b, sz;
    logic [2:0] code;
    logic [2:0] r;
    r = 3'b000;  // {hit, bank}
    for (int n = 3; n >= 0; n--) begin
      b = {32'h0, m_bank[n] & 32'hFF80_0000};
      code = m_bank[n][19:17];
      sz = 64'h40_0000 << code;
      if (m_cfg[31] && m_bank[n][0] && code != 3'd7 && {32'h0, a} >= b && {32'h0, a} < b + sz)
        r = {1'b1, 2'(n)};
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [9:0] i, input logic [31:0] v);
    @(negedge clk);
    idx = i; wdata = v; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    if (i == PI) m_ptr = v;
    else if (i == WI) model_win_write(m_ptr, v);
  endtask

  task automatic win_write(input logic [31:0] off, input logic [31:0] v);
    reg_write(PI, off);
    reg_write(WI, v);
  endtask

  task automatic read_check(input string tag, input logic [9:0] i);
    @(negedge clk);
    idx = i;
    #1;
    check(tag, rdata, model_read(i));
  endtask

  task automatic win_check(input string tag, input logic [31:0] off);
    reg_write(PI, off);
    read_check(tag, WI);
  endtask

  task automatic irq_check(input string tag);
    #1;
    check(tag, {31'h0, irq}, {31'h0, m_irq});
  endtask

  task automatic dec_check(input string tag, input logic [31:0] a);
    logic [2:0] e;
    @(negedge clk);
    daddr = a;
    #1;
    e = model_dec(a);
    check(tag, {29'h0, hit, (hit ? hbank : 2'b00)}, {29'h0, e});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] offs [15];
    logic [31:0] off, v, a, b, sz;
    int k;
    offs = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34, 32'h40,
             32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h0C};
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    foreach (offs[j]) win_check("R1 reset value", offs[j]);
    irq_check("R1 irq low");
    dec_check("R1 no hit", 32'h0000_0000);

    // R2 pointer and window
    reg_write(PI, 32'h0000_0010);
    read_check("R2 pointer readback", PI);
    reg_write(WI, 32'hDEAD_BEEF);
    read_check("R2 error address", WI);

    // R3 undefined, timing and foreign index
    win_check("R3 undefined offset", 32'h0000_0004);
    win_check("R3 offset beyond map", 32'h0000_0144);
    win_write(32'h80, 32'hFFFF_FFFF);
    read_check("R3 timing reads ones", WI);
    reg_write(10'h005, 32'h1234_5678);
    read_check("R3 foreign index reads zero", 10'h005);
    read_check("R3 foreign write leaves pointer", PI);

    // R4 / R5
    win_write(32'h00, 32'hFFFF_FFFF);
    read_check("R4 err0 clear", WI);
    win_write(32'h08, 32'h0000_0000);
    read_check("R4 err1 hold", WI);
    win_write(32'h24, 32'hFFFF_FFFF);
    read_check("R5 status ignores write", WI);

    // R6 / R7 configuration edges
    win_write(32'h20, 32'h801F_FFFF);
    read_check("R6 cfg mask", WI);
    win_check("R6 enable clears status", 32'h24);
    win_write(32'h20, 32'h0000_0000);
    win_check("R6 disable sets status", 32'h24);
    win_write(32'h20, 32'hC000_0000);
    win_check("R7 aux rise sets status", 32'h24);
    win_write(32'h20, 32'h8000_0000);
    win_check("R7 aux fall clears status", 32'h24);

    // R8 masks
    win_write(32'h30, 32'hFFFF_FFFF);
    read_check("R8 refresh mask", WI);
    win_write(32'h34, 32'h0000_0000);
    read_check("R8 power fixed bits", WI);
    win_write(32'h94, 32'hFFFF_FFFF);
    read_check("R8 ecc cfg mask", WI);

    // R10 ECC interrupt
    win_write(32'h98, 32'hFFFF_FFFF);
    read_check("R10 esr mask", WI);
    irq_check("R10 irq rises");
    win_write(32'h98, 32'h0000_1000);
    irq_check("R10 irq stays high");
    win_write(32'h98, 32'h000F_0FFF);
    irq_check("R10 irq falls on masked zero");

    // R9 bank mask
    win_write(32'h44, 32'hFFFF_FFFF);
    read_check("R9 bank mask", WI);

    // decoder directed
    win_write(32'h40, 32'h0004_0001);   // base 0, 16 MiB
    win_write(32'h44, 32'h0100_0001);   // base 16 MiB, 4 MiB
    win_write(32'h48, 32'h0000_0001);   // base 0, 4 MiB, overlaps bank 0
    win_write(32'h4C, 32'hF00C_0001);   // base 0xF0000000, 256 MiB
    dec_check("R13 overlap lowest wins", 32'h0000_0100);
    dec_check("R11 bank1 last byte", 32'h013F_FFFF);
    dec_check("R11 bank1 past end", 32'h0140_0000);
    dec_check("R11 bank3 top of space", 32'hFFFF_FFFF);
    dec_check("R11 bank3 below base", 32'hEFFF_FFFF);
    win_write(32'h48, 32'h000E_0001);   // code 7
    win_write(32'h40, 32'h0004_0000);   // bank0 disabled
    dec_check("R12 invalid code never hits", 32'h0000_0100);
    win_write(32'h20, 32'h0000_0000);
    dec_check("R6 disable unmaps banks", 32'hF000_0000);
    win_write(32'h20, 32'h8000_0000);
    dec_check("R11 re-enable maps banks", 32'hF000_0000);

    // random mix
    for (int it = 0; it < 400; it++) begin
      k = $urandom % 15;
      off = (k == 14) ? ($urandom & 32'h0000_01FC) : offs[k];
      v = $urandom;
      if (off == 32'h20 && ($urandom % 2)) v[31] = 1'b1;
      if (off >= 32'h40 && off <= 32'h4C && ($urandom % 2)) v[0] = 1'b1;
      win_write(off, v);
      read_check("R2 random window readback", WI);
      irq_check("R10 random irq");
      k = $urandom % 4;
      b = m_bank[k] & 32'hFF80_0000;
      sz = 32'h40_0000 << m_bank[k][19:17];
      case ($urandom % 5)
        0: a = b;
        1: a = b + sz - 1;
        2: a = b + sz;
        3: a = b + ($urandom & 32'h00FF_FFFF);
        default: a = $urandom;
      endcase
      dec_check("R13 random decode", a);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule